// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words of 18 bits are stored in an inferred two-port array whose depth is a power of two set by a parameter. In a product build the depth is 8K to 64K; the default here is smaller so that simulation stays quick. Each side has its own active-low enable. A single active-low reset is asserted asynchronously and released separately inside each clock domain.

Five active-low status outputs describe the fill level: empty, almost empty, half full, almost full and full. Empty, almost empty and half full are registered on the read clock. Full and almost full are registered on the write clock. Each side sees the opposite pointer through a two-stage Gray-code synchroniser. The two almost thresholds are distances from empty and from full. A neighbouring offset-register block supplies them, together with a flag for each one that says whether it has been loaded. An unloaded threshold falls back to 127 words.

Top module: `dcfifo_flags`

## Requirements
- R1: While `wen_n` is low and `full_n` is high, each rising `wclk` edge stores `din`. While `ren_n` is low and `empty_n` is high, each rising `rclk` edge loads the oldest stored word into `dout`. Words leave in the order they were written.
- R2: While `rst_n` is low, the block is held in reset: `empty_n`=0, `almost_empty_n`=0, `half_full_n`=1, `almost_full_n`=1, `full_n`=1 and `dout`=0.
- R3: `full_n` goes low when DEPTH words are stored and is updated only by `wclk`. While it is low, `wen_n` has no effect and stored words are not overwritten.
- R4: `empty_n` goes low when no word is stored and is updated only by `rclk`. While it is low, `ren_n` has no effect and the read position does not advance.
- R5: While `empty_n` is low, `dout` keeps the last word that was read, even if read attempts continue.
- R6: `almost_empty_n` is low whenever the occupancy is less than or equal to the empty-side threshold.
- R7: `almost_full_n` is low whenever the free space (DEPTH minus occupancy) is less than or equal to the full-side threshold.
- R8: `half_full_n` is low whenever the occupancy is at least DEPTH/2.
- R9: When `ae_offset_vld` is 0, the empty-side threshold is 127, and when it is 1 the threshold is `ae_offset`. `af_offset_vld` selects between 127 and `af_offset` for the full side in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wen_n | input | 1 | Active-low write enable |
| din | input | DATA_W (18) | Write data |
| ren_n | input | 1 | Active-low read enable |
| dout | output | DATA_W (18) | Registered read data |
| ae_offset | input | OFF_W (16) | Programmed distance from empty |
| ae_offset_vld | input | 1 | Empty-side distance has been loaded |
| af_offset | input | OFF_W (16) | Programmed distance from full |
| af_offset_vld | input | 1 | Full-side distance has been loaded |
| empty_n | output | 1 | Empty, active low (read clock) |
| almost_empty_n | output | 1 | Almost empty, active low (read clock) |
| half_full_n | output | 1 | At least half full, active low (read clock) |
| almost_full_n | output | 1 | Almost full, active low (write clock) |
| full_n | output | 1 | Full, active low (write clock) |

## Verification
The bench steps the occupancy across each flag's threshold, one word either side. It does this with the default distances and again with small programmed distances. A compare with an off-by-one error, or the wrong distance selected, moves a flag edge by one word. The bench keeps writing into a full buffer, then drains it and checks every word. A design that overwrote a word or advanced its write pointer would return a corrupted sequence. The bench also keeps reading an empty buffer. A design that let a read through would change `dout` or skip the next word written.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  // Threshold used when the offset-register block has not loaded a distance
  localparam int unsigned DEF_OFFSET = 127;

  typedef struct packed {
    logic empty_n;
    logic almost_empty_n;
    logic half_full_n;
  } rd_flags_t;

  typedef struct packed {
    logic full_n;
    logic almost_full_n;
  } wr_flags_t;

endpackage

// File: rtl/dcfifo_rst_sync.sv
module dcfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/dcfifo_ptr_sync.sv
module dcfifo_ptr_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_out[i] = ^sync_q[W-1:i];
  end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 16
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wen_n,
  input  logic [ADDR_W:0]   rptr_sync,
  input  logic [OFF_W-1:0]  af_offset,
  input  logic              af_offset_vld,
  output logic              mem_we,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wptr_bin,
  output logic [ADDR_W:0]   wptr_gray,
  output wr_flags_t         flags
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int CMP_W = (OFF_W > PTR_W) ? OFF_W : PTR_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PTR_W-1:0] ptr_q, ptr_d, gray_q, gray_d, used_d;
  logic [CMP_W-1:0] free_d, thr;
  wr_flags_t        flags_q, flags_d;
  logic             do_wr;

  assign do_wr = !wen_n && flags_q.full_n;

  always_comb begin
    ptr_d  = ptr_q + PTR_W'(do_wr);
    gray_d = ptr_d ^ (ptr_d >> 1);
    used_d = ptr_d - rptr_sync;
    free_d = CMP_W'(DEPTH) - CMP_W'(used_d);
    thr    = af_offset_vld ? CMP_W'(af_offset) : CMP_W'(DEF_OFFSET);
    flags_d.full_n        = (used_d != PTR_W'(DEPTH));
    flags_d.almost_full_n = !(free_d <= thr);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      ptr_q   <= '0;
      gray_q  <= '0;
      flags_q <= '{full_n: 1'b1, almost_full_n: 1'b1};
    end else begin
      if (do_wr) begin
        ptr_q  <= ptr_d;
        gray_q <= gray_d;
      end
      flags_q <= flags_d;
    end
  end

  assign mem_we    = do_wr;
  assign waddr     = ptr_q[ADDR_W-1:0];
  assign wptr_bin  = ptr_q;
  assign wptr_gray = gray_q;
  assign flags     = flags_q;
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 18
) (
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              ren_n,
  input  logic [ADDR_W:0]   wptr_sync,
  input  logic [OFF_W-1:0]  ae_offset,
  input  logic              ae_offset_vld,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rptr_bin,
  output logic [ADDR_W:0]   rptr_gray,
  output logic [DATA_W-1:0] dout,
  output rd_flags_t         flags
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int CMP_W = (OFF_W > PTR_W) ? OFF_W : PTR_W;
  localparam int HALF  = 1 << (ADDR_W - 1);

  logic [PTR_W-1:0]  ptr_q, ptr_d, gray_q, gray_d, used_d;
  logic [CMP_W-1:0]  thr;
  logic [DATA_W-1:0] dout_q;
  rd_flags_t         flags_q, flags_d;
  logic              do_rd;

  assign do_rd = !ren_n && flags_q.empty_n;

  always_comb begin
    ptr_d  = ptr_q + PTR_W'(do_rd);
    gray_d = ptr_d ^ (ptr_d >> 1);
    used_d = wptr_sync - ptr_d;
    thr    = ae_offset_vld ? CMP_W'(ae_offset) : CMP_W'(DEF_OFFSET);
    flags_d.empty_n        = (used_d != '0);
    flags_d.almost_empty_n = !(CMP_W'(used_d) <= thr);
    flags_d.half_full_n    = !(used_d >= PTR_W'(HALF));
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      ptr_q   <= '0;
      gray_q  <= '0;
      dout_q  <= '0;
      flags_q <= '{empty_n: 1'b0, almost_empty_n: 1'b0, half_full_n: 1'b1};
    end else begin
      if (do_rd) begin
        ptr_q  <= ptr_d;
        gray_q <= gray_d;
        dout_q <= rdata;
      end
      flags_q <= flags_d;
    end
  end

  assign raddr     = ptr_q[ADDR_W-1:0];
  assign rptr_bin  = ptr_q;
  assign rptr_gray = gray_q;
  assign dout      = dout_q;
  assign flags     = flags_q;
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 16
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wen_n,
  input  logic [DATA_W-1:0] din,
  input  logic              ren_n,
  output logic [DATA_W-1:0] dout,
  input  logic [OFF_W-1:0]  ae_offset,
  input  logic              ae_offset_vld,
  input  logic [OFF_W-1:0]  af_offset,
  input  logic              af_offset_vld,
  output logic              empty_n,
  output logic              almost_empty_n,
  output logic              half_full_n,
  output logic              almost_full_n,
  output logic              full_n
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic              wrst_n, rrst_n, mem_we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wr_ptr, wr_gray, rd_ptr, rd_gray, wptr_sync, rptr_sync;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] mem [DEPTH];
  wr_flags_t         wflags;
  rd_flags_t         rflags;

  dcfifo_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  dcfifo_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  dcfifo_ptr_sync #(.W(PTR_W)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .gray_in(rd_gray), .bin_out(rptr_sync));
  dcfifo_ptr_sync #(.W(PTR_W)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .gray_in(wr_gray), .bin_out(wptr_sync));

  dcfifo_wr_ctl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wen_n(wen_n), .rptr_sync(rptr_sync),
    .af_offset(af_offset), .af_offset_vld(af_offset_vld),
    .mem_we(mem_we), .waddr(waddr), .wptr_bin(wr_ptr), .wptr_gray(wr_gray),
    .flags(wflags));

  dcfifo_rd_ctl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .ren_n(ren_n), .wptr_sync(wptr_sync),
    .ae_offset(ae_offset), .ae_offset_vld(ae_offset_vld), .rdata(rdata),
    .raddr(raddr), .rptr_bin(rd_ptr), .rptr_gray(rd_gray), .dout(dout),
    .flags(rflags));

  // Storage array: written on the write clock, read asynchronously into dout register
  always_ff @(posedge wclk) begin
    if (mem_we) mem[waddr] <= din;
  end
  assign rdata = mem[raddr];

  assign empty_n        = rflags.empty_n;
  assign almost_empty_n = rflags.almost_empty_n;
  assign half_full_n    = rflags.half_full_n;
  assign full_n         = wflags.full_n;
  assign almost_full_n  = wflags.almost_full_n;
endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              full_n,
  input logic              almost_full_n,
  input logic              empty_n,
  input logic              almost_empty_n,
  input logic              half_full_n,
  input logic [DATA_W-1:0] dout,
  input logic [ADDR_W:0]   wr_ptr,
  input logic [ADDR_W:0]   rd_ptr
);
  // R3: a full buffer never advances its write position
  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wr_ptr));

  // R4: an empty buffer never advances its read position
  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rd_ptr));

  // R5: output word held while empty
  p_hold_dout_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(dout));

  // R6: empty implies almost empty
  p_empty_in_ae_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !almost_empty_n);

  // R7: full implies almost full
  p_full_in_af_r7: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !almost_full_n);

  // R8: half full and empty are exclusive
  p_half_not_empty_r8: assert property (@(posedge rclk) disable iff (!rst_n)
    !half_full_n |-> empty_n);
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
  .full_n(full_n), .almost_full_n(almost_full_n),
  .empty_n(empty_n), .almost_empty_n(almost_empty_n), .half_full_n(half_full_n),
  .dout(dout), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr));

// File: tb/dcfifo_flags_bench.sv
`timescale 1ns/1ps
module dcfifo_flags_bench;
  localparam int DATA_W = 18;
  localparam int ADDR_W = 8;
  localparam int OFF_W  = 16;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NVEC   = 11;

  // Vector layout: [22:14] words written, [13:5] words read,
  // [4:0] expected {empty_n, almost_empty_n, half_full_n, almost_full_n, full_n}
  localparam logic [22:0] TBL [NVEC] = '{
    {9'd0,   9'd0,   5'b00111},
    {9'd1,   9'd0,   5'b10111},
    {9'd126, 9'd0,   5'b10111},
    {9'd1,   9'd0,   5'b11011},
    {9'd1,   9'd0,   5'b11001},
    {9'd127, 9'd0,   5'b11000},
    {9'd0,   9'd1,   5'b11001},
    {9'd0,   9'd127, 5'b11011},
    {9'd0,   9'd1,   5'b10111},
    {9'd0,   9'd126, 5'b10111},
    {9'd0,   9'd1,   5'b00111}
  };

  logic              wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic              wen_n = 1'b1, ren_n = 1'b1;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic [OFF_W-1:0]  ae_offset = '0, af_offset = '0;
  logic              ae_offset_vld = 1'b0, af_offset_vld = 1'b0;
  logic              empty_n, almost_empty_n, half_full_n, almost_full_n, full_n;

  int checks = 0, errors = 0, wseq = 0, rseq = 0;
  bit done = 1'b0;

  always #4 wclk = ~wclk;
  always #5 rclk = ~rclk;

  dcfifo_flags #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dcfifo_flags (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .din(din),
    .ren_n(ren_n), .dout(dout), .ae_offset(ae_offset), .ae_offset_vld(ae_offset_vld),
    .af_offset(af_offset), .af_offset_vld(af_offset_vld), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n), .half_full_n(half_full_n),
    .almost_full_n(almost_full_n), .full_n(full_n));

  function automatic logic [DATA_W-1:0] pat(input int s);
    return DATA_W'(s * 911 + 3);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_flags(input logic [4:0] e);
    check("R4 empty_n",        32'(empty_n),        32'(e[4]));
    check("R6 almost_empty_n", 32'(almost_empty_n), 32'(e[3]));
    check("R8 half_full_n",    32'(half_full_n),    32'(e[2]));
    check("R7 almost_full_n",  32'(almost_full_n),  32'(e[1]));
    check("R3 full_n",         32'(full_n),         32'(e[0]));
  endtask

  task automatic settle();
    repeat (10) @(negedge wclk);
    repeat (10) @(negedge rclk);
  endtask

  task automatic wr(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wen_n = 1'b0;
      din   = pat(wseq);
      wseq++;
    end
    @(negedge wclk);
    wen_n = 1'b1;
  endtask

  // R1: each read returns the next word in write order
  task automatic rd(input int n);
    if (n > 0) begin
      @(negedge rclk);
      ren_n = 1'b0;
      for (int i = 0; i < n; i++) begin
        @(negedge rclk);
        check("R1 data order", 32'(dout), 32'(pat(rseq)));
        rseq++;
      end
      ren_n = 1'b1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] held;
    // R2: reset state
    repeat (3) @(negedge wclk);
    check("R2 dout", 32'(dout), 32'h0);
    chk_flags(5'b00111);
    rst_n = 1'b1;
    settle();

    // Table walk with default thresholds (R9 default 127)
    for (int v = 0; v < NVEC; v++) begin
      wr(int'(TBL[v][22:14]));
      settle();
      rd(int'(TBL[v][13:5]));
      settle();
      chk_flags(TBL[v][4:0]);
    end

    // R3: writes into a full buffer are ignored
    wr(DEPTH);
    settle();
    check("R3 full reached", 32'(full_n), 32'h0);
    for (int i = 0; i < 5; i++) begin
      @(negedge wclk);
      wen_n = 1'b0;
      din   = '1;
    end
    @(negedge wclk);
    wen_n = 1'b1;
    settle();
    check("R3 still full", 32'(full_n), 32'h0);
    rd(DEPTH);
    settle();
    check("R4 empty after drain", 32'(empty_n), 32'h0);
    check("R5 last word kept", 32'(dout), 32'(pat(rseq - 1)));

    // R4/R5: reads of an empty buffer are ignored
    held = dout;
    @(negedge rclk);
    ren_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge rclk);
      check("R5 dout held on empty read", 32'(dout), 32'(held));
    end
    ren_n = 1'b1;
    wr(1);
    settle();
    rd(1);  // R4: must return the new word, no position skipped
    settle();
    check("R4 empty again", 32'(empty_n), 32'h0);

    // R9: programmed thresholds
    ae_offset = 16'd4; ae_offset_vld = 1'b1;
    af_offset = 16'd2; af_offset_vld = 1'b1;
    wr(4);
    settle();
    check("R9 ae at 4 words", 32'(almost_empty_n), 32'h0);
    wr(1);
    settle();
    check("R9 ae at 5 words", 32'(almost_empty_n), 32'h1);
    wr(249);
    settle();
    check("R9 af at 2 free", 32'(almost_full_n), 32'h0);
    check("R3 not full at 254", 32'(full_n), 32'h1);
    rd(1);
    settle();
    check("R9 af at 3 free", 32'(almost_full_n), 32'h1);
    rd(253);
    settle();
    ae_offset_vld = 1'b0;
    af_offset_vld = 1'b0;
    settle();
    chk_flags(5'b00111);

    // R2: reset in the middle of operation
    wr(10);
    settle();
    rd(1);
    @(negedge wclk);
    rst_n = 1'b0;
    #1;
    check("R2 dout cleared", 32'(dout), 32'h0);
    chk_flags(5'b00111);
    repeat (3) @(negedge rclk);
    rst_n = 1'b1;
    rseq = wseq;
    settle();
    chk_flags(5'b00111);
    wr(3);
    settle();
    rd(3);
    settle();
    check("R4 empty after reset run", 32'(empty_n), 32'h0);

    finish_run();
  end
endmodule